// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a compact stored-program processor built around one 16-bit accumulator. It steps through a fetch, decode and execute loop, one register-transfer micro-step per clock. Every memory access goes through a 12-bit address register and a 16-bit buffer register. The core talks to an external single-port memory of 4096 words that is addressed by word. That memory has a synchronous read with one cycle of latency. Each instruction word holds a 4-bit operation code in bits 15..12 and a 12-bit direct address in bits 11..0.

The core also has a byte-wide input channel with a valid/ready handshake and a byte-wide output channel that raises a one-cycle valid strobe. It runs programs from address 0 after reset until it executes a halt. It then raises a halted flag and stays idle. If a conditional skip uses an undefined condition code, a sticky error flag is set.

Top module: `acc_core`

## Requirements
- R1: While reset is high and on the first cycle after it, mem_we, out_valid, in_ready, halted and cond_err are low and mem_addr is 0. Execution begins by fetching the word at address 0.
- R2: The fetch reads the word at PC and then adds 1 to PC modulo 4096, so the next fetch after the one at address 4095 is at address 0. The operation code is bits 15..12 of the word and the operand address is bits 11..0.
- R3: Code 1 loads the word at the operand address into AC. Code 3 adds that word to AC and code 4 subtracts it from AC. Both use 16-bit two's complement arithmetic that wraps on overflow.
- R4: Code 2 writes AC to the operand address. mem_we is high for exactly one cycle, with that address on mem_addr and AC on mem_wdata.
- R5: Code 8 tests AC against the condition in bits 11..10. The value 00 means AC negative, 01 means AC zero and 10 means AC greater than zero. When the condition holds, PC advances by one more word, so the following instruction is skipped.
- R6: Code 8 with bits 11..10 equal to 11 sets cond_err, does not skip, and cond_err stays high until reset.
- R7: Code 9 loads PC with the operand address.
- R8: Code 5 raises in_ready and waits with no other effect until in_valid is high. It then sets AC to the 8-bit in_data extended with zeros and drops in_ready in the following cycle.
- R9: Code 6 places AC bits 7..0 on out_data and raises out_valid for exactly one cycle.
- R10: Code 7 raises halted, which stays high. After that there are no memory writes, no out_valid and no in_ready.
- R11: Codes 0 and 10 to 15 change no architectural state, and execution continues with the next word.
- R12: Codes 1, 3 and 4 take 7 cycles each. Codes 2, 6, 7, 8, 9 and the unused codes take 5 cycles each. Code 5 takes 5 cycles when in_valid is already high. halted rises at the end of the last cycle of the halt instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory word address (registered) |
| mem_wdata | output | 16 | Memory write data (registered) |
| mem_we | output | 1 | Memory write enable (registered) |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| in_data | input | 8 | Input channel byte |
| in_valid | input | 1 | Input channel byte is valid |
| in_ready | output | 1 | Core is waiting for an input byte |
| out_data | output | 8 | Output register contents |
| out_valid | output | 1 | One-cycle strobe marking a new output byte |
| halted | output | 1 | Core has executed a halt |
| cond_err | output | 1 | Sticky flag for an undefined skip condition |

## Verification
Four programs are run, and a behavioural instruction-level model in the bench predicts every store, every output byte and the cycle at which the core halts.
- An add program with a negative operand shows that arithmetic uses signed wrap.
- A skip-and-jump program drives AC to negative, zero and positive values and tries each condition both true and false. A wrong condition or a wrong skip distance then shows up as an extra or missing store or output.
- A third program mixes unused codes with the undefined skip condition, which separates no-operations from real effects.
- A last program jumps to the top address to force PC to wrap, and holds in_valid low to show the input stall and the zero extension.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'd1;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'd2;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'd3;
  localparam logic [OPC_W-1:0] OPC_SUB   = 4'd4;
  localparam logic [OPC_W-1:0] OPC_IN    = 4'd5;
  localparam logic [OPC_W-1:0] OPC_OUT   = 4'd6;
  localparam logic [OPC_W-1:0] OPC_HALT  = 4'd7;
  localparam logic [OPC_W-1:0] OPC_SKIP  = 4'd8;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 4'd9;

  localparam logic [1:0] COND_NEG  = 2'b00;
  localparam logic [1:0] COND_ZERO = 2'b01;
  localparam logic [1:0] COND_POS  = 2'b10;

  typedef enum logic [3:0] {
    ST_FETCH_A,
    ST_FETCH_B,
    ST_FETCH_C,
    ST_DECODE,
    ST_OPER_A,
    ST_OPER_B,
    ST_ARITH,
    ST_STORE,
    ST_INWAIT,
    ST_EXEC,
    ST_HALT
  } step_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  input  logic          do_sub,
  output logic [DW-1:0] res
);

  always_comb begin
    if (do_sub) res = lhs - rhs;
    else        res = lhs + rhs;
  end

endmodule

// File: rtl/acc_skip_eval.sv
module acc_skip_eval
  import acc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] acc,
  input  logic [1:0]    sel,
  output logic          take,
  output logic          bad
);

  logic is_neg;
  logic is_zero;

  assign is_neg  = acc[DW-1];
  assign is_zero = (acc == '0);

  always_comb begin
    take = 1'b0;
    bad  = 1'b0;
    case (sel)
      COND_NEG:  take = is_neg;
      COND_ZERO: take = is_zero;
      COND_POS:  take = !is_neg && !is_zero;
      default:   bad  = 1'b1;
    endcase
  end

endmodule

// File: rtl/acc_out_port.sv
module acc_out_port #(
  parameter int IOW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [IOW-1:0] din,
  output logic [IOW-1:0] dout,
  output logic           strobe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout   <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= load;
      if (load) dout <= din;
    end
  end

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int AW  = 12,
  parameter int IOW = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic [AW-1:0]         mem_addr,
  output logic [OPC_W+AW-1:0]   mem_wdata,
  output logic                  mem_we,
  input  logic [OPC_W+AW-1:0]   mem_rdata,
  input  logic [IOW-1:0]        in_data,
  input  logic                  in_valid,
  output logic                  in_ready,
  output logic [IOW-1:0]        out_data,
  output logic                  out_valid,
  output logic                  halted,
  output logic                  cond_err
);

  localparam int DW = OPC_W + AW;

  step_t             state;
  logic [AW-1:0]     pc;
  logic [AW-1:0]     mar;
  logic [DW-1:0]     mbr;
  logic [DW-1:0]     ir;
  logic [DW-1:0]     ac;
  logic              we_q;
  logic              rdy_q;
  logic              halt_q;
  logic              err_q;

  logic [OPC_W-1:0]  opc;
  logic [AW-1:0]     opnd;
  logic [1:0]        cond;
  logic [DW-1:0]     alu_y;
  logic              skip_take;
  logic              skip_bad;
  logic              out_load;

  assign opc  = ir[DW-1 -: OPC_W];
  assign opnd = ir[AW-1:0];
  assign cond = ir[AW-1 -: 2];

  acc_alu #(.DW(DW)) u_alu (
    .lhs    (ac),
    .rhs    (mbr),
    .do_sub (opc == OPC_SUB),
    .res    (alu_y)
  );

  acc_skip_eval #(.DW(DW)) u_skip (
    .acc  (ac),
    .sel  (cond),
    .take (skip_take),
    .bad  (skip_bad)
  );

  assign out_load = (state == ST_EXEC) && (opc == OPC_OUT);

  acc_out_port #(.IOW(IOW)) u_out (
    .clk    (clk),
    .rst    (rst),
    .load   (out_load),
    .din    (ac[IOW-1:0]),
    .dout   (out_data),
    .strobe (out_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_FETCH_A;
      pc     <= '0;
      mar    <= '0;
      mbr    <= '0;
      ir     <= '0;
      ac     <= '0;
      we_q   <= 1'b0;
      rdy_q  <= 1'b0;
      halt_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (state)
        ST_FETCH_A: begin
          mar   <= pc;
          state <= ST_FETCH_B;
        end
        ST_FETCH_B: state <= ST_FETCH_C;
        ST_FETCH_C: begin
          ir    <= mem_rdata;
          pc    <= pc + AW'(1);
          state <= ST_DECODE;
        end
        ST_DECODE: begin
          mar <= opnd;
          case (opc)
            OPC_LOAD, OPC_ADD, OPC_SUB: state <= ST_OPER_A;
            OPC_STORE: begin
              mbr   <= ac;
              we_q  <= 1'b1;
              state <= ST_STORE;
            end
            OPC_IN: begin
              rdy_q <= 1'b1;
              state <= ST_INWAIT;
            end
            default: state <= ST_EXEC;
          endcase
        end
        ST_OPER_A: state <= ST_OPER_B;
        ST_OPER_B: begin
          mbr   <= mem_rdata;
          state <= ST_ARITH;
        end
        ST_ARITH: begin
          if (opc == OPC_LOAD) ac <= mbr;
          else                 ac <= alu_y;
          state <= ST_FETCH_A;
        end
        ST_STORE: begin
          we_q  <= 1'b0;
          state <= ST_FETCH_A;
        end
        ST_INWAIT: begin
          if (in_valid) begin
            ac    <= {{(DW-IOW){1'b0}}, in_data};
            rdy_q <= 1'b0;
            state <= ST_FETCH_A;
          end
        end
        ST_EXEC: begin
          state <= ST_FETCH_A;
          case (opc)
            OPC_SKIP: begin
              if (skip_take) pc <= pc + AW'(1);
              if (skip_bad)  err_q <= 1'b1;
            end
            OPC_JUMP: pc <= opnd;
            OPC_HALT: begin
              halt_q <= 1'b1;
              state  <= ST_HALT;
            end
            default: ;
          endcase
        end
        ST_HALT: state <= ST_HALT;
        default: state <= ST_FETCH_A;
      endcase
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_we    = we_q;
  assign in_ready  = rdy_q;
  assign halted    = halt_q;
  assign cond_err  = err_q;

endmodule

// File: rtl/acc_core_checker.sv
module acc_core_checker (
  input logic clk,
  input logic rst,
  input logic mem_we,
  input logic out_valid,
  input logic in_ready,
  input logic in_valid,
  input logic halted,
  input logic cond_err
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!mem_we && !out_valid && !in_ready && !halted && !cond_err));

  assert_write_single_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    cond_err |=> cond_err);

  assert_ready_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> in_ready);

  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid) |=> !in_ready);

  assert_out_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  assert_halt_idle_R10: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_we && !out_valid && !in_ready));

endmodule

bind acc_core acc_core_checker u_acc_core_checker (
  .clk       (clk),
  .rst       (rst),
  .mem_we    (mem_we),
  .out_valid (out_valid),
  .in_ready  (in_ready),
  .in_valid  (in_valid),
  .halted    (halted),
  .cond_err  (cond_err)
);

// File: tb/acc_core_bench.sv
`timescale 1ns/1ps
module acc_core_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata = 16'h0;
  logic [7:0]  in_data = 8'h0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        halted;
  logic        cond_err;

  always #2 clk = ~clk;

  acc_core u_acc_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .halted(halted), .cond_err(cond_err)
  );

  logic [15:0] dmem [int];
  logic [15:0] rmem [int];
  logic [11:0] exp_wa [$];
  logic [15:0] exp_wd [$];
  logic [7:0]  exp_out [$];
  logic [7:0]  stim_in [$];
  logic [7:0]  drv_in [$];
  int  exp_cyc;
  bit  exp_err;

  int  vectors = 0;
  int  fails = 0;
  int  edge_cnt = 0;
  int  acc_cnt = 0;
  int  pop_cnt = 0;
  int  hold_off = 0;
  int  halt_cyc = 0;
  bit  halt_seen = 0;
  bit  running = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // memory with one cycle read latency
  always @(posedge clk) begin
    if (mem_we) dmem[int'(mem_addr)] = mem_wdata;
    mem_rdata <= dmem.exists(int'(mem_addr)) ? dmem[int'(mem_addr)] : 16'h0;
  end

  always @(posedge clk) begin
    if (rst) begin edge_cnt = 0; acc_cnt = 0; end
    else begin
      edge_cnt++;
      if (in_valid && in_ready) acc_cnt++;
    end
  end

  // input driver
  always @(negedge clk) begin
    if (rst) pop_cnt = 0;
    else begin
      while (pop_cnt < acc_cnt) begin
        void'(drv_in.pop_front());
        pop_cnt++;
      end
      if (hold_off > 0) hold_off--;
    end
    in_valid = (drv_in.size() > 0) && (hold_off == 0) && !rst;
    in_data  = (drv_in.size() > 0) ? drv_in[0] : 8'h00;
  end

  // per-clock comparison against the model's event queues
  always @(negedge clk) begin
    if (!rst && running) begin
      if (mem_we) begin
        if (exp_wa.size() == 0) chk(1'b0, "R4 unexpected store", {4'h0, mem_addr, mem_wdata}, 32'h0);
        else begin
          chk(mem_addr == exp_wa[0] && mem_wdata == exp_wd[0], "R4 store addr/data",
              {4'h0, mem_addr, mem_wdata}, {4'h0, exp_wa[0], exp_wd[0]});
          void'(exp_wa.pop_front());
          void'(exp_wd.pop_front());
        end
      end
      if (out_valid) begin
        if (exp_out.size() == 0) chk(1'b0, "R9 unexpected output", {24'h0, out_data}, 32'h0);
        else begin
          chk(out_data == exp_out[0], "R9 output byte", {24'h0, out_data}, {24'h0, exp_out[0]});
          void'(exp_out.pop_front());
        end
      end
      if (halted && !halt_seen) begin
        halt_seen = 1;
        halt_cyc  = edge_cnt;
      end
    end
  end

  function automatic logic [15:0] rd(input int a);
    return rmem.exists(a) ? rmem[a] : 16'h0;
  endfunction

  task automatic put(input int a, input logic [15:0] w);
    dmem[a] = w;
    rmem[a] = w;
  endtask

  task automatic clear_all();
    dmem.delete(); rmem.delete();
    exp_wa.delete(); exp_wd.delete(); exp_out.delete();
    stim_in.delete(); drv_in.delete();
  endtask

  // instruction-level reference model
  task automatic model();
    int pc = 0;
    logic [15:0] ac = 16'h0;
    logic [7:0] tmp [$];
    exp_cyc = 0;
    exp_err = 0;
    tmp = stim_in;
    drv_in = stim_in;
    for (int step = 0; step < 10000; step++) begin
      logic [15:0] w;
      logic [3:0] op;
      int a;
      w  = rd(pc);
      pc = (pc + 1) % 4096;
      op = w[15:12];
      a  = int'(w[11:0]);
      if (op == 4'd1 || op == 4'd3 || op == 4'd4) exp_cyc += 7;
      else exp_cyc += 5;
      case (op)
        4'd1: ac = rd(a);
        4'd2: begin rmem[a] = ac; exp_wa.push_back(w[11:0]); exp_wd.push_back(ac); end
        4'd3: ac = ac + rd(a);
        4'd4: ac = ac - rd(a);
        4'd5: ac = {8'h00, tmp.pop_front()};
        4'd6: exp_out.push_back(ac[7:0]);
        4'd7: break;
        4'd8: begin
          case (w[11:10])
            2'b00: if (ac[15]) pc = (pc + 1) % 4096;
            2'b01: if (ac == 16'h0) pc = (pc + 1) % 4096;
            2'b10: if (!ac[15] && ac != 16'h0) pc = (pc + 1) % 4096;
            default: exp_err = 1;
          endcase
        end
        4'd9: pc = a;
        default: ;
      endcase
    end
  endtask

  task automatic run_prog(input string tag, input bit chk_cyc, input int hold);
    int n;
    bit busy;
    model();
    running = 0;
    halt_seen = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!mem_we && !out_valid && !in_ready && !halted && !cond_err && mem_addr == 12'h0,
        {"R1 reset outputs ", tag}, {mem_we, out_valid, in_ready, halted, cond_err, 15'h0, mem_addr},
        32'h0);
    hold_off = hold;
    rst = 0;
    running = 1;
    n = 0;
    while (!halt_seen && n < 5000) begin
      @(posedge clk);
      n++;
    end
    if (!halt_seen) chk(1'b0, {"R10 watchdog no halt ", tag}, n, 0);
    @(negedge clk);
    chk(exp_wa.size() == 0, {"R4 stores missing ", tag}, exp_wa.size(), 0);
    chk(exp_out.size() == 0, {"R9 outputs missing ", tag}, exp_out.size(), 0);
    chk(cond_err == exp_err, {"R6 error flag ", tag}, cond_err, exp_err);
    if (chk_cyc) chk(halt_cyc == exp_cyc, {"R12 cycles to halt ", tag}, halt_cyc, exp_cyc);
    busy = 0;
    repeat (20) begin
      @(negedge clk);
      if (mem_we || out_valid || in_ready || !halted) busy = 1;
    end
    chk(!busy, {"R10 idle after halt ", tag}, busy, 0);
    running = 0;
  endtask

  initial begin
    // R3 R4 R9: load, add negative operand, store, output
    clear_all();
    put(0, 16'h1104); put(1, 16'h3105); put(2, 16'h2106);
    put(3, 16'h6000); put(4, 16'h7000);
    put(16'h104, 16'h0023); put(16'h105, 16'hFFE9);
    run_prog("add_store", 1, 0);
    chk(exp_cyc == 29, "R12 model cycle total", exp_cyc, 29);

    // R5 R7 R3: every skip condition true and false, jump, subtract wrap
    clear_all();
    put(16'h00, 16'h1040); put(16'h01, 16'h4041); put(16'h02, 16'h8000);
    put(16'h03, 16'h6000); put(16'h04, 16'h8400); put(16'h05, 16'h2050);
    put(16'h06, 16'h8800); put(16'h07, 16'h6000); put(16'h08, 16'h9020);
    put(16'h09, 16'h2051);
    put(16'h20, 16'h1042); put(16'h21, 16'h8800); put(16'h22, 16'h6000);
    put(16'h23, 16'h8400); put(16'h24, 16'h4042); put(16'h25, 16'h8400);
    put(16'h26, 16'h6000); put(16'h27, 16'h8000); put(16'h28, 16'h2052);
    put(16'h29, 16'h1043); put(16'h2A, 16'h4044); put(16'h2B, 16'h2053);
    put(16'h2C, 16'h7000);
    put(16'h40, 16'h0005); put(16'h41, 16'h0009); put(16'h42, 16'h0007);
    put(16'h43, 16'h8000); put(16'h44, 16'h0001);
    run_prog("skip_jump", 1, 0);

    // R11 R6: unused codes as no-ops, undefined skip condition
    clear_all();
    put(0, 16'hA000); put(1, 16'h0123); put(2, 16'hF000);
    put(3, 16'h8C00); put(4, 16'h6000); put(5, 16'h7000);
    run_prog("nop_err", 1, 0);

    // R2 R8: PC wrap from 4095, input stall and zero extension
    clear_all();
    put(16'h000, 16'h9FFF); put(16'hFFF, 16'h8400);
    put(16'h001, 16'h5000); put(16'h002, 16'h2060); put(16'h003, 16'h6000);
    put(16'h004, 16'h5000); put(16'h005, 16'h4061); put(16'h006, 16'h2062);
    put(16'h007, 16'h7000); put(16'h061, 16'h0081);
    stim_in.push_back(8'hA5); stim_in.push_back(8'h80);
    run_prog("wrap_input", 0, 40);

    // R8 same program with input ready at once: exact timing
    stim_in.delete();
    stim_in.push_back(8'hA5); stim_in.push_back(8'h80);
    exp_wa.delete(); exp_wd.delete(); exp_out.delete();
    rmem.delete(); dmem.delete();
    put(16'h000, 16'h9FFF); put(16'hFFF, 16'h8400);
    put(16'h001, 16'h5000); put(16'h002, 16'h2060); put(16'h003, 16'h6000);
    put(16'h004, 16'h5000); put(16'h005, 16'h4061); put(16'h006, 16'h2062);
    put(16'h007, 16'h7000); put(16'h061, 16'h0081);
    run_prog("input_nowait", 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule